// File: doc/BRIEF.md
# Warp Issue Scheduler for a Dual-Pipe SIMT Core

This block is the issue stage at the front of one streaming multiprocessor. It watches a pool of eight warp slots. Each slot says whether it has an instruction waiting and whether that instruction needs the main arithmetic pipe or the special-function pipe. In each front-end cycle the block picks at most one eligible warp and sends its instruction to the matching pipe. A warp is 32 threads, and the issued instruction applies to all of them.

Both pipes belong to a backend that runs at twice the front-end clock. The block models that backend as a per-pipe occupancy counter in the front-end clock domain:

- The main pipe has 8 lanes. It covers 16 threads per front-end cycle, so it holds a warp for 2 front-end cycles.
- The special-function pipe has 2 lanes. It covers 4 threads per front-end cycle, so it holds a warp for 8 front-end cycles.

Two main-pipe instructions in a row therefore leave a gap cycle. A special-function instruction can fill that gap. Each pipe reports completion with a one-cycle pulse that names the warp. That warp may then issue again.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, issue_valid, both busy outputs and both done pulses are low. The first grant goes to the lowest-numbered eligible warp.
- R2: At most one warp issues per cycle. issue_pipe equals that warp's warp_is_sfu bit, where 0 is the main pipe and 1 is the special-function pipe.
- R3: A main-pipe issue in cycle t makes main_busy high in cycle t+1 only. main_done pulses in cycle t+1 with main_done_warp equal to the issued warp.
- R4: A special-function issue in cycle t makes sfu_busy high in cycles t+1 to t+7. sfu_done pulses only in cycle t+7, with sfu_done_warp equal to the issued warp.
- R5: A warp is eligible only if three things hold: its warp_ready bit is high, it has no instruction in flight, and its target pipe is not busy in that cycle.
- R6: Among eligible warps, the grant goes to the first one found by scanning upward, with wrap-around, from the slot after the most recently issued warp.
- R7: A warp that has issued is not granted again until its pipe's done pulse has named it. It is eligible again from the cycle after that pulse.
- R8: When the main pipe is busy and a warp is ready for the idle special-function pipe, the block issues in that cycle. A main, special, main pattern therefore issues on three consecutive cycles.
- R9: If no warp is eligible, issue_valid stays low and the round-robin start point does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Front-end clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | 8 | Per-slot flag: the slot has an instruction pending |
| warp_is_sfu | input | 8 | Per-slot pipe type of the pending instruction (1 = special-function) |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | 3 | Slot that issues |
| issue_pipe | output | 1 | Target pipe of the issue (1 = special-function) |
| main_busy | output | 1 | Main pipe is still working through a warp |
| main_done | output | 1 | One-cycle pulse when the main pipe finishes a warp |
| main_done_warp | output | 3 | Warp named by main_done |
| sfu_busy | output | 1 | Special-function pipe is still working through a warp |
| sfu_done | output | 1 | One-cycle pulse when the special-function pipe finishes a warp |
| sfu_done_warp | output | 3 | Warp named by sfu_done |

## Verification
The embedded properties assume only that the inputs have known values at each rising edge. The pending flags and pipe types may change freely from cycle to cycle, even while a warp is in flight. The stimulus keeps to this by changing inputs just after each rising edge. It then holds them steady until the next edge, through directed phases and a long pseudo-random phase. The behavioural model in the bench uses the same reading of the inputs: a warp's pipe type is taken from the cycle in which the warp issues.

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS    = 8,
  parameter int WARP_THREADS = 32,
  parameter int MAIN_TPC     = 16,
  parameter int SFU_TPC      = 4,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int MAIN_CYC = WARP_THREADS / MAIN_TPC,
  localparam int SFU_CYC  = WARP_THREADS / SFU_TPC,
  localparam int CNT_W    = $clog2(SFU_CYC + MAIN_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic [NUM_WARPS-1:0] warp_is_sfu,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic                 issue_pipe,
  output logic                 main_busy,
  output logic                 main_done,
  output logic [WID_W-1:0]     main_done_warp,
  output logic                 sfu_busy,
  output logic                 sfu_done,
  output logic [WID_W-1:0]     sfu_done_warp
);

  logic [CNT_W-1:0]     m_cnt, s_cnt;
  logic [WID_W-1:0]     m_wid, s_wid, last_q, pick, idx;
  logic [NUM_WARPS-1:0] infl_q, infl_d, elig;
  logic                 found;

  assign main_busy      = m_cnt != '0;
  assign sfu_busy       = s_cnt != '0;
  assign main_done      = m_cnt == CNT_W'(1);
  assign sfu_done       = s_cnt == CNT_W'(1);
  assign main_done_warp = m_wid;
  assign sfu_done_warp  = s_wid;

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_elig
    assign elig[i] = warp_ready[i] & ~infl_q[i] &
                     (warp_is_sfu[i] ? ~sfu_busy : ~main_busy);
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      idx = WID_W'((int'(last_q) + k) % NUM_WARPS);
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  assign issue_valid = found;
  assign issue_warp  = pick;
  assign issue_pipe  = warp_is_sfu[pick];

  always_comb begin
    infl_d = infl_q;
    if (main_done)   infl_d[m_wid] = 1'b0;
    if (sfu_done)    infl_d[s_wid] = 1'b0;
    if (issue_valid) infl_d[pick]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      s_cnt  <= '0;
      m_wid  <= '0;
      s_wid  <= '0;
      infl_q <= '0;
      last_q <= WID_W'(NUM_WARPS - 1);
    end else begin
      infl_q <= infl_d;
      if (main_busy) m_cnt <= m_cnt - CNT_W'(1);
      if (sfu_busy)  s_cnt <= s_cnt - CNT_W'(1);
      if (issue_valid) begin
        last_q <= pick;
        if (issue_pipe) begin
          s_cnt <= CNT_W'(SFU_CYC - 1);
          s_wid <= pick;
        end else begin
          m_cnt <= CNT_W'(MAIN_CYC - 1);
          m_wid <= pick;
        end
      end
    end
  end

  AST_MAIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_pipe |-> !main_busy); // R5
  AST_SFU_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_pipe |-> !sfu_busy); // R5
  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> warp_ready[issue_warp]); // R5
  AST_MAIN_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_pipe |=> main_busy && main_done && main_done_warp == $past(issue_warp)); // R3
  AST_SFU_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_pipe |=> sfu_busy && !sfu_done && sfu_done_warp == $past(issue_warp)); // R4
  AST_SFU_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sfu_busy) |-> $past(sfu_done)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    main_done |=> !main_done); // R3

endmodule

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] warp_ready = '0, warp_is_sfu = '0;
  logic issue_valid, issue_pipe, main_busy, main_done, sfu_busy, sfu_done;
  logic [2:0] issue_warp, main_done_warp, sfu_done_warp;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_is_sfu(warp_is_sfu),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_pipe(issue_pipe),
    .main_busy(main_busy), .main_done(main_done), .main_done_warp(main_done_warp),
    .sfu_busy(sfu_busy), .sfu_done(sfu_done), .sfu_done_warp(sfu_done_warp));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int cm = 0, cs = 0, wm = 0, ws = 0, last = NW - 1;
  bit infl [NW];
  bit e_valid, e_pipe;
  int e_warp;

  always @(negedge clk) if (rst_n) begin
    bit mb, sb;
    mb = cm != 0;
    sb = cs != 0;
    e_valid = 0; e_warp = 0; e_pipe = 0;
    for (int k = 1; k <= NW; k++) begin
      int id;
      id = (last + k) % NW;
      if (!e_valid && warp_ready[id] && !infl[id] && (warp_is_sfu[id] ? !sb : !mb)) begin
        e_valid = 1; e_warp = id; e_pipe = warp_is_sfu[id];
      end
    end
    chk(issue_valid == e_valid, "R5 R9 issue_valid", issue_valid, e_valid);
    if (e_valid && issue_valid) begin
      chk(issue_warp == e_warp, "R6 R7 issue_warp", issue_warp, e_warp);
      chk(issue_pipe == e_pipe, "R2 issue_pipe", issue_pipe, e_pipe);
    end
    chk(main_busy == mb, "R3 main_busy", main_busy, mb);
    chk(sfu_busy == sb, "R4 sfu_busy", sfu_busy, sb);
    chk(main_done == (cm == 1), "R3 main_done", main_done, cm == 1);
    chk(sfu_done == (cs == 1), "R4 sfu_done", sfu_done, cs == 1);
    if (cm == 1) chk(main_done_warp == wm, "R3 main_done_warp", main_done_warp, wm);
    if (cs == 1) chk(sfu_done_warp == ws, "R4 sfu_done_warp", sfu_done_warp, ws);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cm = 0; cs = 0; wm = 0; ws = 0; last = NW - 1;
      foreach (infl[i]) infl[i] = 0;
    end else begin
      if (cm == 1) infl[wm] = 0;
      if (cs == 1) infl[ws] = 0;
      if (cm > 0) cm--;
      if (cs > 0) cs--;
      if (e_valid) begin
        infl[e_warp] = 1;
        last = e_warp;
        if (e_pipe) begin cs = 7; ws = e_warp; end
        else begin cm = 1; wm = e_warp; end
      end
    end
  end

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    int cnt;
    repeat (3) next_cycle();
    rst_n = 1'b1;
    @(negedge clk);
    chk(!issue_valid && !main_busy && !sfu_busy, "R1 idle after reset", issue_valid, 0);
    chk(!main_done && !sfu_done, "R1 no done after reset", main_done, 0);
    next_cycle();
    // R1: first grant lowest slot; all main ready
    warp_ready = '1; warp_is_sfu = '0;
    @(negedge clk);
    chk(issue_valid && issue_warp == 0, "R1 first grant", issue_warp, 0);
    repeat (20) next_cycle();
    // drain, R9 idle
    warp_ready = '0;
    repeat (12) next_cycle();
    @(negedge clk);
    chk(!issue_valid, "R9 idle no issue", issue_valid, 0);
    // R8 main, special, main on consecutive cycles
    next_cycle();
    cnt = 0;
    warp_ready = 8'b0000_0010; warp_is_sfu = 8'b0001_0000;
    @(negedge clk); cnt += int'(issue_valid);
    next_cycle();
    warp_ready = 8'b0001_0010;
    @(negedge clk); cnt += int'(issue_valid);
    chk(issue_valid && issue_pipe, "R8 special fills gap", issue_pipe, 1);
    next_cycle();
    warp_ready = 8'b0001_1010;
    @(negedge clk); cnt += int'(issue_valid);
    chk(cnt == 3, "R8 three consecutive issues", cnt, 3);
    next_cycle();
    // alternating even main / odd special
    warp_ready = '1; warp_is_sfu = 8'b1010_1010;
    repeat (60) next_cycle();
    // all special
    warp_is_sfu = '1;
    repeat (40) next_cycle();
    warp_ready = '0;
    repeat (12) next_cycle();
    // pseudo-random phase
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      warp_ready = lfsr[7:0];
      warp_is_sfu = lfsr[15:8];
      next_cycle();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule